// File: doc/BRIEF.md
# Multi-lane stereo serial audio frame capture

This block takes in several stereo serial audio data lines. All of them share one bit clock and one word-select clock, and both clocks come from an external converter. The block rebuilds the two 32-bit channel words of every line. It runs on a system clock that is much faster than the bit clock. The bit clock and word select are brought into that domain through two-stage synchronisers. A data bit is taken on each detected rising edge of the bit clock, together with the word-select level seen at that edge. Each lane has two shift registers. One collects the bits sent while word select is low, which form the first-channel word. The other collects the bits sent while word select is high, which form the second-channel word. Both words are shifted in most significant bit first.

A shared phase counter checks the length of every word-select phase. The block locks only after it has watched a high phase of exactly 32 bits from its first bit to its last. A word is latched when word select changes level, so the first bit of the next word can never end up in the previous word, however fast the frames arrive. After the second-channel word of a frame is latched, one valid pulse covers all lanes. A phase of the wrong length drops the lock and raises an error pulse, and the block then waits for the next complete high phase. Deasserting enable clears all state.

Top module: `i2s_frame_capture`

## Requirements
- R1: While reset is active, or enable is low, the word outputs are all zero and frame_valid and phase_err stay low.
- R2: For each lane, left_words holds the 32 bits sampled while word select was low, with the first sampled bit at bit 31. The word is latched when word select goes high.
- R3: For each lane, right_words holds the 32 bits sampled while word select was high, with the first sampled bit at bit 31. The word is latched when word select goes low.
- R4: frame_valid is a one-cycle pulse that rises in the same cycle a new right_words value appears. right_words does not change in any other cycle while enabled.
- R5: Lock needs a high phase whose first and last bits were both observed, and which holds exactly 32 bits. The first high phase after enable never counts. No frame is delivered before lock.
- R6: While locked, a phase that ends with fewer than 32 bits raises phase_err for one cycle and drops the lock. No frame_valid is given for the broken frame.
- R7: While locked, a 33rd bit at the same word-select level raises phase_err at that bit, without waiting for the level change. Lock is regained only through a later complete high phase.
- R8: All lanes latch their words on the same bit-clock edges, so one frame_valid covers matching frames on every lane.
- R9: Dropping enable clears the words, the counters and the synchroniser state at once. No frame_valid appears again until a new lock.
- R10: Capture stays bit-exact with a bit clock of only four system clocks per period, with no bit slipping into the neighbouring word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Capture enable; low clears all state |
| sck | input | 1 | External bit clock |
| ws | input | 1 | External word select, low = first channel |
| sd | input | LANES | Serial data lines, one per lane |
| left_words | output | LANES*WORD_BITS | First-channel words, lane n at bits n*WORD_BITS upward |
| right_words | output | LANES*WORD_BITS | Second-channel words, same packing |
| frame_valid | output | 1 | One-cycle pulse when a whole frame is latched |
| phase_err | output | 1 | One-cycle pulse on a phase of wrong length while locked |

## Verification
The bench starts capture with a full high phase already running. A design that trusted that first phase would deliver one frame too early. It then cuts one phase to 31 bits and stretches another to 33. A design that only checked at the level change would flag the long phase late, and one that kept its lock would pass on a mixed frame. Enable is dropped in the middle of a word to catch state left behind in the synchronisers or shift registers. The run is repeated at a bit-clock period of four system clocks, where a design that latched one edge late would slip a bit between channels.

// File: rtl/i2s_frame_capture.sv
module i2s_frame_capture #(
  parameter int LANES     = 4,
  parameter int WORD_BITS = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enable,
  input  logic                       sck,
  input  logic                       ws,
  input  logic [LANES-1:0]           sd,
  output logic [LANES*WORD_BITS-1:0] left_words,
  output logic [LANES*WORD_BITS-1:0] right_words,
  output logic                       frame_valid,
  output logic                       phase_err
);
  localparam int CW = $clog2(WORD_BITS + 2);
  localparam logic [CW-1:0] FULL = CW'(WORD_BITS);
  localparam logic [CW-1:0] OVER = CW'(WORD_BITS + 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [1:0]       sck_q, ws_q;
  logic             sck_d;
  logic [LANES-1:0] sd_q1, sd_q2;
  logic             primed, whole, prev_ws, locked;
  logic [CW-1:0]    cnt;

  wire bit_ws     = ws_q[1];
  wire rise       = sck_q[1] & ~sck_d;
  wire boundary   = primed & (bit_ws != prev_ws);
  wire good       = whole & (cnt == FULL);
  wire overrun    = primed & ~boundary & (cnt == FULL);
  wire take_left  = rise & locked & boundary & good & ~prev_ws;
  wire take_right = rise & locked & boundary & good & prev_ws;
  wire bad        = rise & locked & ((boundary & ~good) | overrun);
  wire acquire    = rise & ~locked & boundary & good & prev_ws;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0; ws_q <= '0; sck_d <= 1'b0; sd_q1 <= '0; sd_q2 <= '0;
      primed <= 1'b0; whole <= 1'b0; prev_ws <= 1'b0; locked <= 1'b0;
      cnt <= '0; frame_valid <= 1'b0; phase_err <= 1'b0;
    end else if (!enable) begin
      sck_q <= '0; ws_q <= '0; sck_d <= 1'b0; sd_q1 <= '0; sd_q2 <= '0;
      primed <= 1'b0; whole <= 1'b0; prev_ws <= 1'b0; locked <= 1'b0;
      cnt <= '0; frame_valid <= 1'b0; phase_err <= 1'b0;
    end else begin
      sck_q       <= {sck_q[0], sck};
      ws_q        <= {ws_q[0], ws};
      sck_d       <= sck_q[1];
      sd_q1       <= sd;
      sd_q2       <= sd_q1;
      frame_valid <= take_right;
      phase_err   <= bad;
      if (bad)          locked <= 1'b0;
      else if (acquire) locked <= 1'b1;
      if (rise) begin
        if (!primed) begin
          primed  <= 1'b1;
          prev_ws <= bit_ws;
          cnt     <= ONE;
        end else if (boundary) begin
          prev_ws <= bit_ws;
          cnt     <= ONE;
          whole   <= 1'b1;
        end else if (cnt == FULL) begin
          cnt <= OVER;
        end else if (cnt != OVER) begin
          cnt <= cnt + ONE;
        end
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WORD_BITS-1:0] lsr, rsr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lsr <= '0; rsr <= '0;
        left_words[g*WORD_BITS +: WORD_BITS]  <= '0;
        right_words[g*WORD_BITS +: WORD_BITS] <= '0;
      end else if (!enable) begin
        lsr <= '0; rsr <= '0;
        left_words[g*WORD_BITS +: WORD_BITS]  <= '0;
        right_words[g*WORD_BITS +: WORD_BITS] <= '0;
      end else begin
        if (rise) begin
          if (bit_ws) rsr <= {rsr[WORD_BITS-2:0], sd_q2[g]};
          else        lsr <= {lsr[WORD_BITS-2:0], sd_q2[g]};
        end
        if (take_left)  left_words[g*WORD_BITS +: WORD_BITS]  <= lsr;
        if (take_right) right_words[g*WORD_BITS +: WORD_BITS] <= rsr;
      end
    end
  end
endmodule

// File: rtl/i2s_frame_capture_chk.sv
module i2s_frame_capture_chk #(
  parameter int LANES     = 4,
  parameter int WORD_BITS = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       enable,
  input logic [LANES*WORD_BITS-1:0] left_words,
  input logic [LANES*WORD_BITS-1:0] right_words,
  input logic                       frame_valid,
  input logic                       phase_err
);
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid); // R4
  AST_RIGHT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_valid && $past(enable)) |-> $stable(right_words)); // R4
  AST_ERR_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    phase_err |-> !frame_valid); // R6
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_err |=> !phase_err); // R7
  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!frame_valid && !phase_err && left_words == '0 && right_words == '0)); // R9
endmodule

bind i2s_frame_capture i2s_frame_capture_chk #(.LANES(LANES), .WORD_BITS(WORD_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .left_words(left_words),
  .right_words(right_words), .frame_valid(frame_valid), .phase_err(phase_err)
);

// File: tb/test_i2s_frame_capture.sv
module test_i2s_frame_capture;
  localparam int LANES = 4;
  localparam int WB    = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, enable, sck, ws;
  logic [LANES-1:0] sd;
  logic [LANES*WB-1:0] left_words, right_words;
  logic frame_valid, phase_err;

  i2s_frame_capture #(.LANES(LANES), .WORD_BITS(WB)) i_i2s_frame_capture (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sck(sck), .ws(ws), .sd(sd),
    .left_words(left_words), .right_words(right_words),
    .frame_valid(frame_valid), .phase_err(phase_err));

  int checks = 0, fails = 0, hp = 5, cyc = 0;
  int vcount = 0, ecount = 0;
  logic [WB-1:0] last_l [LANES];
  logic [WB-1:0] last_r [LANES];

  function automatic logic [WB-1:0] pat(int f, int lane, int side);
    logic [31:0] k;
    k = 32'(f * 16 + lane * 2 + side + 1);
    return (k * 32'h9E3779B9) ^ 32'h5A5A0F0F;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [WB-1:0] act, input logic [WB-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  logic p1_sck, p2_sck, pd_sck, p1_ws, p2_ws;
  logic [LANES-1:0] p1_sd, p2_sd;
  logic m_primed, m_whole, m_prev, m_locked, m_valid, m_err, m_ok;
  int m_cnt;
  logic [WB-1:0] m_l [LANES];
  logic [WB-1:0] m_r [LANES];
  logic [WB-1:0] m_lo [LANES];
  logic [WB-1:0] m_ro [LANES];

  always @(posedge clk) begin
    if (!rst_n || !enable) begin
      p1_sck = 0; p2_sck = 0; pd_sck = 0; p1_ws = 0; p2_ws = 0; p1_sd = '0; p2_sd = '0;
      m_primed = 0; m_whole = 0; m_prev = 0; m_locked = 0; m_valid = 0; m_err = 0; m_cnt = 0;
      for (int l = 0; l < LANES; l++) begin m_l[l] = '0; m_r[l] = '0; m_lo[l] = '0; m_ro[l] = '0; end
    end else begin
      m_valid = 0; m_err = 0;
      if (p2_sck && !pd_sck) begin
        if (!m_primed) begin
          m_primed = 1; m_prev = p2_ws; m_cnt = 1;
        end else if (p2_ws != m_prev) begin
          m_ok = m_whole && (m_cnt == WB);
          if (m_locked) begin
            if (!m_ok) begin m_err = 1; m_locked = 0; end
            else if (!m_prev) begin for (int l = 0; l < LANES; l++) m_lo[l] = m_l[l]; end
            else begin for (int l = 0; l < LANES; l++) m_ro[l] = m_r[l]; m_valid = 1; end
          end else if (m_ok && m_prev) m_locked = 1;
          m_prev = p2_ws; m_cnt = 1; m_whole = 1;
        end else begin
          if (m_cnt == WB && m_locked) begin m_err = 1; m_locked = 0; end
          if (m_cnt <= WB) m_cnt++;
        end
        for (int l = 0; l < LANES; l++) begin
          if (p2_ws) m_r[l] = {m_r[l][WB-2:0], p2_sd[l]};
          else       m_l[l] = {m_l[l][WB-2:0], p2_sd[l]};
        end
      end
      pd_sck = p2_sck; p2_sck = p1_sck; p2_ws = p1_ws; p2_sd = p1_sd;
      p1_sck = sck; p1_ws = ws; p1_sd = sd;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(frame_valid == m_valid, "R4 frame_valid", WB'(frame_valid), WB'(m_valid));
      chk(phase_err == m_err, "R6 phase_err", WB'(phase_err), WB'(m_err));
      for (int l = 0; l < LANES; l++) begin
        chk(left_words[l*WB +: WB] == m_lo[l], "R2 left word", left_words[l*WB +: WB], m_lo[l]);
        chk(right_words[l*WB +: WB] == m_ro[l], "R3 right word", right_words[l*WB +: WB], m_ro[l]);
      end
    end
    if (frame_valid) begin
      vcount++;
      for (int l = 0; l < LANES; l++) begin
        last_l[l] = left_words[l*WB +: WB];
        last_r[l] = right_words[l*WB +: WB];
      end
    end
    if (phase_err) ecount++;
  end

  task automatic send_bit(input logic lvl, input logic [LANES-1:0] d);
    sck = 1'b0; ws = lvl; sd = d;
    repeat (hp) @(negedge clk);
    sck = 1'b1;
    repeat (hp) @(negedge clk);
  endtask

  task automatic phase(input logic lvl, input int n, input int f);
    for (int i = 0; i < n; i++) begin
      logic [LANES-1:0] d;
      for (int l = 0; l < LANES; l++) begin
        logic [WB-1:0] w;
        w = pat(f, l, int'(lvl));
        d[l] = (i < WB) ? w[WB-1-i] : 1'b0;
      end
      send_bit(lvl, d);
    end
  endtask

  task automatic frame(input int f);
    phase(1'b0, WB, f);
    phase(1'b1, WB, f);
  endtask

  task automatic lockup();
    phase(1'b1, WB, 90);
    frame(91);
  endtask

  task automatic restart();
    sck = 1'b0;
    enable = 1'b0;
    repeat (4) @(negedge clk);
    enable = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_last(input int f, input string tag);
    for (int l = 0; l < LANES; l++) begin
      chk(last_l[l] == pat(f, l, 0), tag, last_l[l], pat(f, l, 0));
      chk(last_r[l] == pat(f, l, 1), tag, last_r[l], pat(f, l, 1));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<%0d cycles", cyc, 180000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int v0, e0;
    rst_n = 1'b0; enable = 1'b0; sck = 1'b0; ws = 1'b0; sd = '0;
    repeat (4) @(negedge clk);
    chk(left_words == '0 && right_words == '0, "R1 words in reset", WB'(left_words != '0), '0);
    chk(!frame_valid && !phase_err, "R1 strobes in reset", WB'(frame_valid | phase_err), '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(left_words == '0 && !frame_valid, "R1 idle while disabled", WB'(frame_valid), '0);

    // first high phase after enable does not count (R5), several frames (R2 R3 R8)
    restart(); v0 = vcount; e0 = ecount;
    lockup();
    for (int f = 0; f < 5; f++) frame(f);
    phase(1'b0, WB, 50);
    chk(vcount - v0 == 5, "R5 frames after lock", WB'(vcount - v0), 5);
    chk(ecount == e0, "R6 no error on clean stream", WB'(ecount - e0), 0);
    check_last(4, "R8 lane words frame 4");

    // short phase while locked (R6)
    restart(); v0 = vcount; e0 = ecount;
    lockup(); frame(0);
    phase(1'b0, WB - 1, 1); phase(1'b1, WB, 1);
    frame(2); frame(3); phase(1'b0, WB, 50);
    chk(vcount - v0 == 3, "R6 short phase frames", WB'(vcount - v0), 3);
    chk(ecount - e0 == 1, "R6 short phase error", WB'(ecount - e0), 1);
    check_last(3, "R2 R3 after resync");

    // long phase while locked (R7)
    restart(); v0 = vcount; e0 = ecount;
    lockup(); frame(0);
    phase(1'b0, WB + 1, 1);
    chk(ecount - e0 == 1, "R7 error before level change", WB'(ecount - e0), 1);
    phase(1'b1, WB, 1);
    frame(2); frame(3); phase(1'b0, WB, 50);
    chk(vcount - v0 == 3, "R7 long phase frames", WB'(vcount - v0), 3);
    check_last(3, "R8 lanes after long phase");

    // enable dropped mid word (R9)
    restart(); v0 = vcount;
    lockup(); frame(0); phase(1'b0, 20, 1);
    enable = 1'b0; sck = 1'b0;
    repeat (3) @(negedge clk);
    chk(left_words == '0 && right_words == '0, "R9 words cleared", WB'(right_words[WB-1:0]), '0);
    chk(vcount - v0 == 1, "R9 frames before drop", WB'(vcount - v0), 1);
    enable = 1'b1; v0 = vcount;
    frame(2); frame(3); frame(4); phase(1'b0, WB, 50);
    chk(vcount - v0 == 2, "R9 R5 frames after re-enable", WB'(vcount - v0), 2);
    check_last(4, "R9 words after re-enable");

    // fast bit clock (R10)
    hp = 2;
    restart(); v0 = vcount; e0 = ecount;
    lockup();
    for (int f = 10; f < 15; f++) frame(f);
    phase(1'b0, WB, 50);
    chk(vcount - v0 == 5, "R10 frames at fast clock", WB'(vcount - v0), 5);
    chk(ecount == e0, "R10 no error at fast clock", WB'(ecount - e0), 0);
    check_last(14, "R10 words at fast clock");

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule